// File: doc/BRIEF.md
# Linear-Count Display Timing Generator

This block produces the sync and data-enable timing for a parallel LCD panel from a single pixel-clock domain. A line counter runs across each horizontal period and drives hsync. A second counter runs across the whole frame, one step per pixel clock. It does not count lines. Vsync and the vertical limits of the active window are therefore given as pixel-clock counts, where a line count is multiplied by the horizontal total. Software works the configuration words out from a display mode and holds them stable while the block runs.

Count zero of both counters marks the leading edge of hsync. The horizontal window start is the distance from the start of hsync to the end of the line. A skew value delays the vsync pulse by a few pixel clocks relative to the frame start. A pixel-request strobe leads data-enable by one clock, so that the pixel source can present a pixel in time for it. The output pixel is taken from the source inside the active window and from the border colour outside it. When recovery is enabled, a pixel flagged as underflowed is replaced by a fixed colour.

Clearing the enable input takes effect only at the end of the current frame. A disable followed by a re-enable inside the same frame therefore leaves the timing undisturbed.

Top module: `lcd_frame_timer`

## Requirements
- R1: While reset is asserted and after it is released with enable low, hsync_o equals hsync_low_i, vsync_o equals vsync_low_i, de_o and pix_req_o are 0, and pix_o is 0 until the first clock edge after reset.
- R2: While running, the line count advances from 0 to hperiod_i-1 and wraps. The raw hsync is active for line counts 0 to hpulse_i-1, and hsync_o shows it one clock after that count.
- R3: While running, the frame count advances one step per pixel clock from 0 to fperiod_i-1. Both counts return to 0 after the last frame count. The raw vsync is active for frame counts skew_i to skew_i+vlen_i-1, and vsync_o shows it one clock later.
- R4: de_o is 1 exactly one clock after a count where the line count lies in [hstart_i, hend_i] and the frame count lies in [vstart_i, vend_i], both bounds inclusive.
- R5: pix_req_o is 1 in the cycle whose counts satisfy the R4 window, which is one clock before de_o.
- R6: When hsync_low_i is 1, hsync_o is the inverse of the raw hsync. When vsync_low_i is 1, vsync_o is the inverse of the raw vsync. Both outputs rest at the inactive level while stopped.
- R7: Whenever de_o is 0, pix_o equals border_i, including while stopped.
- R8: When de_o is 1, pix_o is the pix_i value presented with the preceding pix_req_o. If uflow_i was 1 in that cycle and uflow_recover_i is 1, pix_o is uflow_color_i instead. With uflow_recover_i at 0, uflow_i has no effect.
- R9: With the block stopped, enable_i sampled high at a clock edge starts the counts at 0 in the following cycle.
- R10: enable_i sampled low stops the block only at the edge that ends a frame. If enable_i returns high before that edge, the timing continues unbroken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Run request; a clear takes effect at the frame end |
| hperiod_i | input | HW | Horizontal total in pixel clocks |
| hpulse_i | input | HW | Hsync pulse width in pixel clocks |
| fperiod_i | input | FW | Frame total in pixel clocks (lines times horizontal total) |
| vlen_i | input | FW | Vsync length in pixel clocks |
| hstart_i | input | HW | First line count of the active window |
| hend_i | input | HW | Last line count of the active window |
| vstart_i | input | FW | First frame count of the active window |
| vend_i | input | FW | Last frame count of the active window |
| skew_i | input | HW | Vsync delay after frame start, in pixel clocks |
| hsync_low_i | input | 1 | 1 makes hsync active-low |
| vsync_low_i | input | 1 | 1 makes vsync active-low |
| border_i | input | PW | Colour shown outside the active window |
| uflow_recover_i | input | 1 | 1 replaces underflowed pixels |
| uflow_color_i | input | PW | Replacement colour for underflowed pixels |
| pix_i | input | PW | Pixel from the source, valid with pix_req_o |
| uflow_i | input | 1 | Source flags the present pixel as underflowed |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data enable |
| pix_req_o | output | 1 | Pixel request, one clock ahead of de_o |
| pix_o | output | PW | Output pixel |

## Verification
Two events can fall in the same clock edge: a stop request being applied at the frame boundary, and the last pixel or sync pulse of that frame being registered. The bench drops enable_i in the middle of a frame and checks every output against a cycle model up to the boundary and past it. It then repeats with enable_i restored before the boundary, where the outputs must show no gap. A pixel underflow can also land on any active cycle, including the first and last pixels of a line. A periodic underflow pattern runs across complete frames with recovery on and with recovery off, and pix_o is compared cycle by cycle.

// File: rtl/lft_pkg.sv
package lft_pkg;
  // index of each sync channel inside the sync generator
  localparam int SYNC_H = 0;
  localparam int SYNC_V = 1;
  localparam int NSYNC  = 2;

  typedef enum logic { ST_STOP = 1'b0, ST_RUN = 1'b1 } run_state_e;
endpackage

// File: rtl/lft_counters.sv
module lft_counters #(
  parameter int HW = 12,
  parameter int FW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable_i,
  input  logic [HW-1:0] hperiod_i,
  input  logic [FW-1:0] fperiod_i,
  output logic          running_o,
  output logic          frame_end_o,
  output logic [HW-1:0] hcnt_o,
  output logic [FW-1:0] fcnt_o
);
  import lft_pkg::*;

  localparam logic [HW-1:0] H_ONE = 1;
  localparam logic [FW-1:0] F_ONE = 1;

  run_state_e    state_q;
  logic [HW-1:0] hcnt_q;
  logic [FW-1:0] fcnt_q;
  logic          line_end;
  logic          frame_end;

  assign line_end  = (hcnt_q == hperiod_i - H_ONE);
  assign frame_end = (state_q == ST_RUN) && (fcnt_q == fperiod_i - F_ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_STOP;
      hcnt_q  <= '0;
      fcnt_q  <= '0;
    end else if (state_q == ST_STOP) begin
      hcnt_q <= '0;
      fcnt_q <= '0;
      if (enable_i) state_q <= ST_RUN;
    end else if (frame_end) begin
      hcnt_q <= '0;
      fcnt_q <= '0;
      if (!enable_i) state_q <= ST_STOP;
    end else begin
      fcnt_q <= fcnt_q + F_ONE;
      hcnt_q <= line_end ? '0 : hcnt_q + H_ONE;
    end
  end

  assign running_o   = (state_q == ST_RUN);
  assign frame_end_o = frame_end;
  assign hcnt_o      = hcnt_q;
  assign fcnt_o      = fcnt_q;

  // R2: the line count never reaches the horizontal total
  assert_hcnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (running_o && hperiod_i != '0) |-> (hcnt_q < hperiod_i));

  // R10: leaving the run state happens only from the last frame count
  assert_stop_at_frame_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(running_o) |-> $past(frame_end_o));

  // R3: after the last frame count both counters restart together
  assert_frame_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end_o |=> (fcnt_q == '0 && hcnt_q == '0));
endmodule

// File: rtl/lft_sync_gen.sv
module lft_sync_gen #(
  parameter int HW = 12,
  parameter int FW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          running_i,
  input  logic [HW-1:0] hcnt_i,
  input  logic [FW-1:0] fcnt_i,
  input  logic [HW-1:0] hpulse_i,
  input  logic [FW-1:0] vlen_i,
  input  logic [HW-1:0] hstart_i,
  input  logic [HW-1:0] hend_i,
  input  logic [FW-1:0] vstart_i,
  input  logic [FW-1:0] vend_i,
  input  logic [HW-1:0] skew_i,
  input  logic          hsync_low_i,
  input  logic          vsync_low_i,
  output logic          window_o,
  output logic          hsync_o,
  output logic          vsync_o
);
  import lft_pkg::*;

  function automatic logic h_inside(logic [HW-1:0] c, logic [HW-1:0] lo, logic [HW-1:0] hi);
    return (c >= lo) && (c <= hi);
  endfunction

  function automatic logic f_inside(logic [FW-1:0] c, logic [FW-1:0] lo, logic [FW-1:0] hi);
    return (c >= lo) && (c <= hi);
  endfunction

  // pulse that begins at 'first' and lasts 'len' counts, written so it cannot overflow
  function automatic logic f_pulse(logic [FW-1:0] c, logic [FW-1:0] first, logic [FW-1:0] len);
    return (c >= first) && ((c - first) < len);
  endfunction

  logic [NSYNC-1:0] raw_act;
  logic [NSYNC-1:0] low_lvl;
  logic [NSYNC-1:0] sync_out;
  logic [FW-1:0]    skew_f;
  logic [FW-1:0]    hpulse_f;

  assign skew_f   = FW'(skew_i);
  assign hpulse_f = FW'(hpulse_i);

  assign raw_act[SYNC_H] = running_i && f_pulse(FW'(hcnt_i), '0, hpulse_f);
  assign raw_act[SYNC_V] = running_i && f_pulse(fcnt_i, skew_f, vlen_i);
  assign low_lvl[SYNC_H] = hsync_low_i;
  assign low_lvl[SYNC_V] = vsync_low_i;

  assign window_o = running_i && h_inside(hcnt_i, hstart_i, hend_i)
                              && f_inside(fcnt_i, vstart_i, vend_i);

  for (genvar g = 0; g < NSYNC; g++) begin : g_sync
    logic act_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) act_q <= 1'b0;
      else        act_q <= raw_act[g];
    end
    assign sync_out[g] = act_q ^ low_lvl[g];
  end

  assign hsync_o = sync_out[SYNC_H];
  assign vsync_o = sync_out[SYNC_V];
endmodule

// File: rtl/lft_pixel_mux.sv
module lft_pixel_mux #(
  parameter int PW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          window_i,
  input  logic [PW-1:0] pix_i,
  input  logic          uflow_i,
  input  logic          uflow_recover_i,
  input  logic [PW-1:0] uflow_color_i,
  input  logic [PW-1:0] border_i,
  output logic          de_o,
  output logic [PW-1:0] pix_o
);
  logic [PW-1:0] active_pix;
  logic [PW-1:0] next_pix;

  assign active_pix = (uflow_i && uflow_recover_i) ? uflow_color_i : pix_i;
  assign next_pix   = window_i ? active_pix : border_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      de_o  <= 1'b0;
      pix_o <= '0;
    end else begin
      de_o  <= window_i;
      pix_o <= next_pix;
    end
  end

  // R8: a recovered underflow always shows the replacement colour
  assert_uflow_color_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (window_i && uflow_i && uflow_recover_i) |=> (de_o && pix_o == $past(uflow_color_i)));
endmodule

// File: rtl/lcd_frame_timer.sv
module lcd_frame_timer #(
  parameter int HW = 12,
  parameter int FW = 24,
  parameter int PW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable_i,
  input  logic [HW-1:0] hperiod_i,
  input  logic [HW-1:0] hpulse_i,
  input  logic [FW-1:0] fperiod_i,
  input  logic [FW-1:0] vlen_i,
  input  logic [HW-1:0] hstart_i,
  input  logic [HW-1:0] hend_i,
  input  logic [FW-1:0] vstart_i,
  input  logic [FW-1:0] vend_i,
  input  logic [HW-1:0] skew_i,
  input  logic          hsync_low_i,
  input  logic          vsync_low_i,
  input  logic [PW-1:0] border_i,
  input  logic          uflow_recover_i,
  input  logic [PW-1:0] uflow_color_i,
  input  logic [PW-1:0] pix_i,
  input  logic          uflow_i,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          de_o,
  output logic          pix_req_o,
  output logic [PW-1:0] pix_o
);
  logic          running;
  logic          frame_end;
  logic [HW-1:0] hcnt;
  logic [FW-1:0] fcnt;
  logic          window;

  lft_counters #(.HW(HW), .FW(FW)) u_counters (
    .clk(clk), .rst_n(rst_n), .enable_i(enable_i),
    .hperiod_i(hperiod_i), .fperiod_i(fperiod_i),
    .running_o(running), .frame_end_o(frame_end),
    .hcnt_o(hcnt), .fcnt_o(fcnt)
  );

  lft_sync_gen #(.HW(HW), .FW(FW)) u_sync (
    .clk(clk), .rst_n(rst_n), .running_i(running),
    .hcnt_i(hcnt), .fcnt_i(fcnt),
    .hpulse_i(hpulse_i), .vlen_i(vlen_i),
    .hstart_i(hstart_i), .hend_i(hend_i),
    .vstart_i(vstart_i), .vend_i(vend_i),
    .skew_i(skew_i),
    .hsync_low_i(hsync_low_i), .vsync_low_i(vsync_low_i),
    .window_o(window), .hsync_o(hsync_o), .vsync_o(vsync_o)
  );

  lft_pixel_mux #(.PW(PW)) u_pix (
    .clk(clk), .rst_n(rst_n), .window_i(window),
    .pix_i(pix_i), .uflow_i(uflow_i),
    .uflow_recover_i(uflow_recover_i), .uflow_color_i(uflow_color_i),
    .border_i(border_i), .de_o(de_o), .pix_o(pix_o)
  );

  assign pix_req_o = window;

  // R5: a pixel request is followed by data-enable on the next clock
  assert_req_leads_de_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pix_req_o |=> de_o);

  // R5: without a request there is no data-enable on the next clock
  assert_no_de_without_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_req_o |=> !de_o);

  // R6: while stopped, hsync settles at its inactive level
  assert_hsync_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !running |=> (hsync_o == hsync_low_i));

  // R7: outside the active window the border colour is shown
  assert_border_outside_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !window |=> (!de_o && pix_o == $past(border_i)));
endmodule

// File: tb/lcd_frame_timer_bench.sv
module lcd_frame_timer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HW = 12;
  localparam int FW = 24;
  localparam int PW = 24;

  // display mode used by every scenario
  localparam int HT = 20, HD = 12, HSS = 14, HSE = 16;
  localparam int VT = 10, VD = 6,  VSS = 7,  VSE = 8;
  localparam int FP = VT * HT;
  localparam int DE_PER_FRAME = HD * VD;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable_i = 1'b0;
  logic [HW-1:0] hperiod_i, hpulse_i, hstart_i, hend_i, skew_i;
  logic [FW-1:0] fperiod_i, vlen_i, vstart_i, vend_i;
  logic hsync_low_i = 1'b0, vsync_low_i = 1'b0;
  logic [PW-1:0] border_i = '0;
  logic uflow_recover_i = 1'b0;
  logic [PW-1:0] uflow_color_i = 24'h0000ff;
  logic [PW-1:0] pix_i = '0;
  logic uflow_i = 1'b0;
  logic hsync_o, vsync_o, de_o, pix_req_o;
  logic [PW-1:0] pix_o;

  int total = 0;
  int bad = 0;
  int skew_v = 0;
  bit uf_pattern = 1'b0;
  bit done = 1'b0;

  lcd_frame_timer #(.HW(HW), .FW(FW), .PW(PW)) u_lcd_frame_timer (
    .clk(clk), .rst_n(rst_n), .enable_i(enable_i),
    .hperiod_i(hperiod_i), .hpulse_i(hpulse_i),
    .fperiod_i(fperiod_i), .vlen_i(vlen_i),
    .hstart_i(hstart_i), .hend_i(hend_i),
    .vstart_i(vstart_i), .vend_i(vend_i),
    .skew_i(skew_i), .hsync_low_i(hsync_low_i), .vsync_low_i(vsync_low_i),
    .border_i(border_i), .uflow_recover_i(uflow_recover_i),
    .uflow_color_i(uflow_color_i), .pix_i(pix_i), .uflow_i(uflow_i),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o),
    .pix_req_o(pix_req_o), .pix_o(pix_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string what, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // configuration words worked out from the mode, as software would
  task automatic program_mode(input int skew);
    skew_v    = skew;
    hperiod_i = HW'(HT);
    hpulse_i  = HW'(HSE - HSS);
    hstart_i  = HW'(HT - HSS);
    hend_i    = HW'(HT - (HSS - HD) - 1);
    fperiod_i = FW'(FP);
    vlen_i    = FW'((VSE - VSS) * HT);
    vstart_i  = FW'((VT - VSS) * HT + skew);
    vend_i    = FW'(FP - (VSS - VD) * HT + skew - 1);
    skew_i    = HW'(skew);
  endtask

  // mode-level expectations: position within the line and within the frame
  function automatic bit exp_hs(int k);
    return (k % HT) < (HSE - HSS);
  endfunction
  function automatic bit exp_vs(int k);
    int f = k % FP;
    return (f >= skew_v) && (f < skew_v + (VSE - VSS) * HT);
  endfunction
  function automatic bit exp_win(int k);
    int f = k % FP;
    int x = k % HT;
    int line_in = ((f - skew_v) >= (VT - VSS) * HT) && ((f - skew_v) < FP - (VSS - VD) * HT);
    return (x >= HT - HSS) && (x < HT - HSS + HD) && (line_in != 0);
  endfunction

  task automatic do_reset(input string tag);
    enable_i = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check(hsync_o == hsync_low_i && vsync_o == vsync_low_i, {tag, " R1 sync idle in reset"},
          {hsync_o, vsync_o}, {hsync_low_i, vsync_low_i});
    check(de_o == 1'b0 && pix_req_o == 1'b0 && pix_o == '0, {tag, " R1 de/req/pix in reset"},
          {de_o, pix_req_o, pix_o}, 0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #1;
  endtask

  // cycle model run: enable low while sample index is in [dis_k, ren_k)
  task automatic run_model(input int ncyc, input int dis_k, input int ren_k,
                           input int de_expect, input string tag);
    int lim = ncyc + 10;
    int e_h = 0, e_v = 0, e_de = 0, e_req = 0, e_pix = 0, de_seen = 0;
    longint a_h = 0, x_h = 0, a_v = 0, x_v = 0, a_de = 0, x_de = 0;
    longint a_rq = 0, x_rq = 0, a_px = 0, x_px = 0;
    logic [PW-1:0] prev_pix = '0;
    bit prev_uf = 1'b0;
    for (int c = FP - 1; c < ncyc; c += FP) begin
      if (c >= dis_k && c < ren_k) begin
        lim = c + 1;
        break;
      end
    end
    enable_i = 1'b1;
    for (int j = 0; j < ncyc; j++) begin
      bit eh, ev, ed, er;
      logic [PW-1:0] ep;
      @(posedge clk);
      #1;
      er = (j < lim) && exp_win(j);
      if (j == 0 || (j - 1) >= lim) begin
        eh = hsync_low_i; ev = vsync_low_i; ed = 1'b0; ep = border_i;
      end else begin
        eh = exp_hs(j - 1) ^ hsync_low_i;
        ev = exp_vs(j - 1) ^ vsync_low_i;
        ed = exp_win(j - 1);
        ep = ed ? ((prev_uf && uflow_recover_i) ? uflow_color_i : prev_pix) : border_i;
      end
      if (hsync_o !== eh) begin if (e_h == 0) begin a_h = hsync_o; x_h = eh; end e_h++; end
      if (vsync_o !== ev) begin if (e_v == 0) begin a_v = vsync_o; x_v = ev; end e_v++; end
      if (de_o !== ed) begin if (e_de == 0) begin a_de = de_o; x_de = ed; end e_de++; end
      if (pix_req_o !== er) begin if (e_req == 0) begin a_rq = pix_req_o; x_rq = er; end e_req++; end
      if (pix_o !== ep) begin if (e_pix == 0) begin a_px = pix_o; x_px = ep; end e_pix++; end
      if (de_o === 1'b1) de_seen++;
      enable_i = !(j >= dis_k && j < ren_k);
      pix_i    = PW'(24'h0a0000 + j);
      uflow_i  = uf_pattern && ((j % 7) == 3);
      prev_pix = pix_i;
      prev_uf  = uflow_i;
    end
    enable_i = 1'b0;
    uflow_i  = 1'b0;
    check(e_h == 0,   {tag, " R2 R9 hsync timing"}, a_h, x_h);
    check(e_v == 0,   {tag, " R3 vsync timing"}, a_v, x_v);
    check(e_de == 0,  {tag, " R4 de window"}, a_de, x_de);
    check(e_req == 0, {tag, " R5 pixel request"}, a_rq, x_rq);
    check(e_pix == 0, {tag, " R7 R8 pixel value"}, a_px, x_px);
    check(de_seen == de_expect, {tag, " R4 de count"}, de_seen, de_expect);
  endtask

  task automatic t_basic();
    do_reset("basic");
    program_mode(0);
    hsync_low_i = 1'b0; vsync_low_i = 1'b0; border_i = 24'h000000;
    uflow_recover_i = 1'b0; uf_pattern = 1'b0;
    run_model(2 * FP + 1, 1 << 30, 1 << 30, 2 * DE_PER_FRAME, "basic R9");
  endtask

  task automatic t_polarity_border();
    hsync_low_i = 1'b1; vsync_low_i = 1'b1; border_i = 24'h123456;
    do_reset("polarity");
    program_mode(0);
    run_model(2 * FP + 1, 1 << 30, 1 << 30, 2 * DE_PER_FRAME, "polarity R6 border R7");
    hsync_low_i = 1'b0;
  endtask

  task automatic t_skew();
    vsync_low_i = 1'b0; border_i = 24'h0f0f0f;
    do_reset("skew");
    program_mode(3);
    run_model(2 * FP + 1, 1 << 30, 1 << 30, 2 * DE_PER_FRAME, "skew R3");
  endtask

  task automatic t_underflow_on();
    do_reset("uflow_on");
    program_mode(0);
    border_i = 24'h00aa00; uflow_recover_i = 1'b1; uflow_color_i = 24'h0000ff; uf_pattern = 1'b1;
    run_model(FP + 1, 1 << 30, 1 << 30, DE_PER_FRAME, "underflow recover R8");
  endtask

  task automatic t_underflow_off();
    do_reset("uflow_off");
    program_mode(0);
    uflow_recover_i = 1'b0; uf_pattern = 1'b1;
    run_model(FP + 1, 1 << 30, 1 << 30, DE_PER_FRAME, "underflow ignored R8");
    uf_pattern = 1'b0;
  endtask

  task automatic t_reenable();
    do_reset("reenable");
    program_mode(0);
    border_i = 24'h000000;
    run_model(2 * FP + 1, 50, 80, 2 * DE_PER_FRAME, "reenable in frame R10");
  endtask

  task automatic t_disable();
    do_reset("disable");
    program_mode(0);
    run_model(2 * FP + 50, FP + 50, 1 << 30, 2 * DE_PER_FRAME, "disable at frame end R10");
    check(pix_req_o == 1'b0 && de_o == 1'b0 && hsync_o == hsync_low_i,
          "R10 stopped after frame end", {pix_req_o, de_o, hsync_o}, {2'b00, hsync_low_i});
  endtask

  initial begin
    program_mode(0);
    t_basic();
    t_polarity_border();
    t_skew();
    t_underflow_on();
    t_underflow_off();
    t_reenable();
    t_disable();
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule